// File: doc/BRIEF.md
# I2C Master Framing Control Register

This block is the host-visible framing register of an I2C master. It watches the bus lines for Start and Stop conditions from any master and keeps a bus-busy flag. It keeps a master-mode flag that follows only the conditions this device produces. It holds two self-clearing generation requests, one for a Start and one for a repeated Start.

Each pending request goes to a separate bit-level engine as a one-cycle strobe. The engine answers with a done pulse, and the pulse clears the matching request bit. A Start request waits while the bus is busy. A repeated Start is only issued while the device is master. The whole register stays in reset until at least one bit of the configuration enable input is set.

The raw bus lines pass through a parameterised synchronizer inside the block. All condition detection works on the synchronized copies.

Top module: `i2c_mctl`

## Requirements
- R1: Readback layout: bit 0 is the Start request, bit 1 the repeated-Start request, bit 2 master mode and bit 3 bus busy. Bits 7:4 always read 0. Write data in bits 7:2 has no effect.
- R2: The bus-busy flag (bit 3) is set by a Start condition and cleared by a Stop condition, from any master. A Start is SDA falling while SCL is high; a Stop is SDA rising while SCL is high. The flag changes SYNC_STAGES+1 rising edges after the line change is sampled.
- R3: Master mode (bit 2) sets on the edge where `eng_start_done` arrives while a Start strobe is outstanding. It clears on the edge where `eng_stop_done` is high. If both arrive on the same edge, the set wins.
- R4: A write with bit 0 at 1 sets the Start request. A write with bit 0 at 0 leaves it unchanged.
- R5: `start_req` is a one-cycle pulse. It is raised only when the Start request is pending, the bus is not busy and no strobe is outstanding. A request held off by a busy bus is issued on the edge right after bus busy clears.
- R6: A done pulse clears its request bit only while a strobe of that kind is outstanding. A done pulse with no matching strobe outstanding is ignored. A clearing done pulse wins over a write of 1 on the same edge.
- R7: A write with bit 1 at 1 sets the repeated-Start request. `restart_req` is a one-cycle pulse, raised only while master mode is 1 and no strobe is outstanding.
- R8: When both requests are pending and nothing is outstanding, the repeated Start is served if master mode is 1 and the Start otherwise. The other request stays pending.
- R9: While every bit of `cfg_en` is 0, all readback bits and both strobes are held at 0 and writes are ignored.
- R10: At most one strobe is outstanding. No new strobe is issued until the outstanding one receives its done pulse, and the two strobes are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_en | input | EN_W | Enable bits; block held in reset while all are 0 |
| wr_en | input | 1 | Register write strobe |
| wr_data | input | 8 | Register write data |
| scl_in | input | 1 | Raw SCL line level |
| sda_in | input | 1 | Raw SDA line level |
| eng_start_done | input | 1 | Engine has completed a Start |
| eng_restart_done | input | 1 | Engine has completed a repeated Start |
| eng_stop_done | input | 1 | Engine has completed a Stop it generated |
| rd_data | output | 8 | Register readback |
| start_req | output | 1 | One-cycle Start generation strobe |
| restart_req | output | 1 | One-cycle repeated-Start strobe |

## Verification
The bench builds the block with SYNC_STAGES=3 and EN_W=3. The deeper synchronizer moves the bus-busy latency away from its default value, so the reference model's delay bookkeeping is exercised rather than assumed. The three enable bits let the bench show that any single set bit releases the reset and that clearing all of them forces it again. With these values the bench reaches the busy-gated Start that waits for a foreign master's Stop, the ordering when both requests are written together, stray done pulses, a done pulse that collides with a write, and a disable that drops a stranded repeated-Start request.

// File: rtl/i2c_mctl_pkg.sv
// Package: shared bit positions and types for the I2C master framing register.
// Assumes: an 8-bit register, of which only the low four bits are implemented.
package i2c_mctl_pkg;

    localparam int REG_W       = 8;
    localparam int BIT_START   = 0;
    localparam int BIT_RESTART = 1;
    localparam int BIT_MMODE   = 2;
    localparam int BIT_BUSY    = 3;
    localparam int LIVE_BITS   = 4;

    // Which generation strobe is waiting for its done pulse
    typedef enum logic [1:0] {
        FL_IDLE    = 2'd0,
        FL_START   = 2'd1,
        FL_RESTART = 2'd2
    } flight_e;

    // Implemented part of the register, most significant first
    typedef struct packed {
        logic busy;
        logic mmode;
        logic restart;
        logic start;
    } status_t;

endpackage

// File: rtl/i2c_mctl_busmon.sv
// Module: i2c_mctl_busmon
// Synchronizes SCL/SDA through SYNC_STAGES flops and compares each line with its
// copy from one cycle earlier. Detects Start (SDA fall, SCL high) and Stop
// (SDA rise, SCL high) from any master and keeps the bus-busy flag.
// Assumes: lines idle high; reset and disable both load the idle level.
module i2c_mctl_busmon #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en,
    input  logic scl_raw,
    input  logic sda_raw,
    output logic start_det,
    output logic stop_det,
    output logic bus_busy
);

    localparam int SW = (SYNC_STAGES < 1) ? 1 : SYNC_STAGES;

    logic [SW-1:0] scl_sh;
    logic [SW-1:0] sda_sh;
    logic          scl_s, sda_s;
    logic          scl_p, sda_p;

    // Synchronizer shift chain for both lines
    always_ff @(posedge clk) begin
        if (!rst_n || !en) begin
            scl_sh <= '1;
            sda_sh <= '1;
        end else begin
            scl_sh[0] <= scl_raw;
            sda_sh[0] <= sda_raw;
            for (int i = 1; i < SW; i++) begin
                scl_sh[i] <= scl_sh[i-1];
                sda_sh[i] <= sda_sh[i-1];
            end
        end
    end

    assign scl_s = scl_sh[SW-1];
    assign sda_s = sda_sh[SW-1];

    // One-cycle-old copies of the synchronized lines
    always_ff @(posedge clk) begin
        if (!rst_n || !en) begin
            scl_p <= 1'b1;
            sda_p <= 1'b1;
        end else begin
            scl_p <= scl_s;
            sda_p <= sda_s;
        end
    end

    // Edge qualification: SDA moves while SCL is held high on both samples
    always_comb begin
        start_det = scl_s & scl_p & sda_p & ~sda_s;
        stop_det  = scl_s & scl_p & ~sda_p & sda_s;
    end

    // Bus-busy flag follows conditions from every master
    always_ff @(posedge clk) begin
        if (!rst_n || !en) begin
            bus_busy <= 1'b0;
        end else if (start_det) begin
            bus_busy <= 1'b1;
        end else if (stop_det) begin
            bus_busy <= 1'b0;
        end
    end

endmodule

// File: rtl/i2c_mctl_arb.sv
// Module: i2c_mctl_arb
// Holds the self-clearing Start / repeated-Start requests and the master-mode
// flag. Issues one registered strobe at a time to the bit engine and clears
// the request on the matching done pulse.
// Assumes: the engine pulses done once per strobe; stray done pulses are ignored.
module i2c_mctl_arb
    import i2c_mctl_pkg::*;
(
    input  logic    clk,
    input  logic    rst_n,
    input  logic    en,
    input  logic    wr_start,
    input  logic    wr_restart,
    input  logic    bus_busy,
    input  logic    eng_start_done,
    input  logic    eng_restart_done,
    input  logic    eng_stop_done,
    output logic    start_pend,
    output logic    restart_pend,
    output logic    mmode,
    output logic    start_req,
    output logic    restart_req,
    output flight_e flight
);

    logic idle;
    logic issue_st, issue_rs;
    logic clr_st, clr_rs;

    // Issue selection and done qualification
    always_comb begin
        idle     = (flight == FL_IDLE);
        issue_rs = restart_pend & idle & mmode;
        issue_st = start_pend & idle & ~bus_busy & ~issue_rs;
        clr_st   = eng_start_done & (flight == FL_START);
        clr_rs   = eng_restart_done & (flight == FL_RESTART);
    end

    // Start request bit: set by write, cleared by its done
    always_ff @(posedge clk) begin
        if (!rst_n || !en)   start_pend <= 1'b0;
        else if (clr_st)     start_pend <= 1'b0;
        else if (wr_start)   start_pend <= 1'b1;
    end

    // Repeated-Start request bit: set by write, cleared by its done
    always_ff @(posedge clk) begin
        if (!rst_n || !en)   restart_pend <= 1'b0;
        else if (clr_rs)     restart_pend <= 1'b0;
        else if (wr_restart) restart_pend <= 1'b1;
    end

    // Outstanding-strobe tracker
    always_ff @(posedge clk) begin
        if (!rst_n || !en)         flight <= FL_IDLE;
        else if (clr_st || clr_rs) flight <= FL_IDLE;
        else if (issue_st)         flight <= FL_START;
        else if (issue_rs)         flight <= FL_RESTART;
    end

    // Master mode follows only conditions this device generated
    always_ff @(posedge clk) begin
        if (!rst_n || !en)      mmode <= 1'b0;
        else if (clr_st)        mmode <= 1'b1;
        else if (eng_stop_done) mmode <= 1'b0;
    end

    // Registered one-cycle strobes to the bit engine
    always_ff @(posedge clk) begin
        if (!rst_n || !en) begin
            start_req   <= 1'b0;
            restart_req <= 1'b0;
        end else begin
            start_req   <= issue_st;
            restart_req <= issue_rs;
        end
    end

endmodule

// File: rtl/i2c_mctl.sv
// Module: i2c_mctl (top)
// Host framing register of an I2C master: bus monitor plus request arbiter,
// with the readback packed from their state. Every bit is held in reset
// until at least one cfg_en bit is set.
// Assumes: wr_data is sampled on the rising edge when wr_en is high.
module i2c_mctl
    import i2c_mctl_pkg::*;
#(
    parameter int SYNC_STAGES = 2,
    parameter int EN_W        = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [EN_W-1:0]  cfg_en,
    input  logic             wr_en,
    input  logic [REG_W-1:0] wr_data,
    input  logic             scl_in,
    input  logic             sda_in,
    input  logic             eng_start_done,
    input  logic             eng_restart_done,
    input  logic             eng_stop_done,
    output logic [REG_W-1:0] rd_data,
    output logic             start_req,
    output logic             restart_req
);

    logic    en_any;
    logic    bus_start_det, bus_stop_det, bus_busy;
    logic    start_pend, restart_pend, mmode;
    logic    wr_start, wr_restart;
    flight_e flight;
    status_t stat;

    // Enable reduction and write decode
    always_comb begin
        en_any     = |cfg_en;
        wr_start   = wr_en & wr_data[BIT_START];
        wr_restart = wr_en & wr_data[BIT_RESTART];
    end

    i2c_mctl_busmon #(.SYNC_STAGES(SYNC_STAGES)) u_mon (
        .clk       (clk),
        .rst_n     (rst_n),
        .en        (en_any),
        .scl_raw   (scl_in),
        .sda_raw   (sda_in),
        .start_det (bus_start_det),
        .stop_det  (bus_stop_det),
        .bus_busy  (bus_busy)
    );

    i2c_mctl_arb u_arb (
        .clk              (clk),
        .rst_n            (rst_n),
        .en               (en_any),
        .wr_start         (wr_start),
        .wr_restart       (wr_restart),
        .bus_busy         (bus_busy),
        .eng_start_done   (eng_start_done),
        .eng_restart_done (eng_restart_done),
        .eng_stop_done    (eng_stop_done),
        .start_pend       (start_pend),
        .restart_pend     (restart_pend),
        .mmode            (mmode),
        .start_req        (start_req),
        .restart_req      (restart_req),
        .flight           (flight)
    );

    // Readback packing; reserved bits read zero
    always_comb begin
        stat.busy    = bus_busy;
        stat.mmode   = mmode;
        stat.restart = restart_pend;
        stat.start   = start_pend;
        rd_data      = {{(REG_W-LIVE_BITS){1'b0}}, stat};
    end

endmodule

// File: rtl/i2c_mctl_chk.sv
// Module: i2c_mctl_chk
// Property checker for i2c_mctl, attached with bind. Observes ports and the
// bus-condition and outstanding-strobe signals of the top.
module i2c_mctl_chk
    import i2c_mctl_pkg::*;
(
    input logic             clk,
    input logic             rst_n,
    input logic             en_any,
    input logic [REG_W-1:0] rd_data,
    input logic             start_req,
    input logic             restart_req,
    input logic             bus_start_det,
    input logic             bus_stop_det,
    input logic             eng_start_done,
    input logic             eng_restart_done,
    input flight_e          flight
);

    // R1: reserved bits always read zero
    p_reserved_zero_r1: assert property (@(posedge clk) disable iff (!rst_n)
        rd_data[REG_W-1:LIVE_BITS] == '0);

    // R2: a detected Start makes the bus busy on the next edge
    p_busy_set_r2: assert property (@(posedge clk) disable iff (!rst_n || !en_any)
        bus_start_det |=> rd_data[BIT_BUSY]);

    // R2: a detected Stop frees the bus on the next edge
    p_busy_clr_r2: assert property (@(posedge clk) disable iff (!rst_n || !en_any)
        bus_stop_det |=> !rd_data[BIT_BUSY]);

    // R5: a Start strobe only follows a cycle where the bus was free
    p_start_gated_r5: assert property (@(posedge clk) disable iff (!rst_n || !en_any)
        start_req |-> !$past(rd_data[BIT_BUSY]));

    // R5: the Start strobe lasts one cycle
    p_start_pulse_r5: assert property (@(posedge clk) disable iff (!rst_n || !en_any)
        start_req |=> !start_req);

    // R7: a repeated-Start strobe only follows a cycle in master mode
    p_restart_mm_r7: assert property (@(posedge clk) disable iff (!rst_n || !en_any)
        restart_req |-> $past(rd_data[BIT_MMODE]));

    // R6: done of the outstanding Start clears the request bit
    p_start_done_r6: assert property (@(posedge clk) disable iff (!rst_n || !en_any)
        (flight == FL_START && eng_start_done) |=> !rd_data[BIT_START]);

    // R6: done of the outstanding repeated Start clears its bit
    p_restart_done_r6: assert property (@(posedge clk) disable iff (!rst_n || !en_any)
        (flight == FL_RESTART && eng_restart_done) |=> !rd_data[BIT_RESTART]);

    // R10: strobes are never high together
    p_excl_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !(start_req && restart_req));

    // R9: with all enables clear the register and strobes go to zero
    p_disabled_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !en_any |=> (rd_data == '0 && !start_req && !restart_req));

endmodule

bind i2c_mctl i2c_mctl_chk u_chk (
    .clk              (clk),
    .rst_n            (rst_n),
    .en_any           (en_any),
    .rd_data          (rd_data),
    .start_req        (start_req),
    .restart_req      (restart_req),
    .bus_start_det    (bus_start_det),
    .bus_stop_det     (bus_stop_det),
    .eng_start_done   (eng_start_done),
    .eng_restart_done (eng_restart_done),
    .flight           (flight)
);

// File: tb/tb_i2c_mctl.sv
// Bench: behavioural reference model compared with the DUT on every clock.
`timescale 1ns/1ps
module tb_i2c_mctl;

    localparam int S  = 3;
    localparam int EW = 3;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [EW-1:0] cfg_en = '0;
    logic          wr_en = 1'b0;
    logic [7:0]    wr_data = '0;
    logic          scl = 1'b1, sda = 1'b1;
    logic          sdone = 1'b0, rdone = 1'b0, pdone = 1'b0;
    logic [7:0]    rd_data;
    logic          start_req, restart_req;

    int n_cmp = 0;
    int n_bad = 0;

    always #2 clk = ~clk;   // 250 MHz

    i2c_mctl #(.SYNC_STAGES(S), .EN_W(EW)) dut (
        .clk(clk), .rst_n(rst_n), .cfg_en(cfg_en), .wr_en(wr_en), .wr_data(wr_data),
        .scl_in(scl), .sda_in(sda), .eng_start_done(sdone),
        .eng_restart_done(rdone), .eng_stop_done(pdone),
        .rd_data(rd_data), .start_req(start_req), .restart_req(restart_req)
    );

    // ---------------- reference model ----------------
    bit m_scl_h[S];
    bit m_sda_h[S];
    bit m_scl_p, m_sda_p;
    bit m_busy, m_mm, m_sg, m_rg, m_sreq, m_rreq;
    int m_fl;   // 0 none, 1 start outstanding, 2 restart outstanding

    task automatic model_reset();
        for (int i = 0; i < S; i++) begin m_scl_h[i] = 1; m_sda_h[i] = 1; end
        m_scl_p = 1; m_sda_p = 1;
        m_busy = 0; m_mm = 0; m_sg = 0; m_rg = 0; m_sreq = 0; m_rreq = 0; m_fl = 0;
    endtask

    initial model_reset();

    always @(posedge clk) begin
        if (!rst_n || cfg_en == '0) begin
            model_reset();
        end else begin
            bit s_scl, s_sda, st, sp, is_r, is_s, c_s, c_r;
            s_scl = m_scl_h[S-1];
            s_sda = m_sda_h[S-1];
            st   = s_scl && m_scl_p && m_sda_p && !s_sda;
            sp   = s_scl && m_scl_p && !m_sda_p && s_sda;
            is_r = m_rg && m_fl == 0 && m_mm;
            is_s = m_sg && m_fl == 0 && !m_busy && !is_r;
            c_s  = sdone && m_fl == 1;
            c_r  = rdone && m_fl == 2;
            if (c_s) m_sg = 0; else if (wr_en && wr_data[0]) m_sg = 1;
            if (c_r) m_rg = 0; else if (wr_en && wr_data[1]) m_rg = 1;
            if (c_s || c_r) m_fl = 0; else if (is_s) m_fl = 1; else if (is_r) m_fl = 2;
            if (c_s) m_mm = 1; else if (pdone) m_mm = 0;
            if (st) m_busy = 1; else if (sp) m_busy = 0;
            m_scl_p = s_scl; m_sda_p = s_sda;
            for (int i = S-1; i > 0; i--) begin
                m_scl_h[i] = m_scl_h[i-1]; m_sda_h[i] = m_sda_h[i-1];
            end
            m_scl_h[0] = scl; m_sda_h[0] = sda;
            m_sreq = is_s; m_rreq = is_r;
        end
    end

    task automatic cmp(input string tag, input logic [7:0] act, input logic [7:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s at %0t: actual %0h expected %0h", tag, $time, act, exp);
        end
    endtask

    // Per-clock comparison, each field tagged with its requirement
    always @(negedge clk) begin
        cmp("R1 reserved", {4'b0, rd_data[7:4]}, 8'h00);
        cmp("R2 busy", {7'b0, rd_data[3]}, {7'b0, m_busy});
        cmp("R3 master mode", {7'b0, rd_data[2]}, {7'b0, m_mm});
        cmp("R4 start pending", {7'b0, rd_data[0]}, {7'b0, m_sg});
        cmp("R7 restart pending", {7'b0, rd_data[1]}, {7'b0, m_rg});
        cmp("R5 start_req", {7'b0, start_req}, {7'b0, m_sreq});
        cmp("R8 restart_req", {7'b0, restart_req}, {7'b0, m_rreq});
        cmp("R10 exclusive strobes", {7'b0, start_req & restart_req}, 8'h00);
    end

    // ---------------- stimulus helpers ----------------
    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr(input logic [7:0] d);
        @(negedge clk); wr_en = 1; wr_data = d;
        @(negedge clk); wr_en = 0; wr_data = '0;
    endtask

    task automatic pulse_start_done();
        @(negedge clk); sdone = 1; @(negedge clk); sdone = 0;
    endtask
    task automatic pulse_restart_done();
        @(negedge clk); rdone = 1; @(negedge clk); rdone = 0;
    endtask
    task automatic pulse_stop_done();
        @(negedge clk); pdone = 1; @(negedge clk); pdone = 0;
    endtask

    task automatic bus_start();
        @(negedge clk); sda = 0; cyc(3); scl = 0; cyc(2);
    endtask
    task automatic bus_stop();
        @(negedge clk); sda = 0; cyc(2); scl = 1; cyc(3); sda = 1; cyc(2);
    endtask

    // Wait for a strobe, returning the number of cycles it took
    task automatic wait_strobe(input bit rs, output int dly);
        dly = 0;
        while ((rs ? restart_req : start_req) !== 1'b1 && dly < 40) begin
            @(negedge clk); dly++;
        end
    endtask

    // ---------------- scenario ----------------
    initial begin
        int d;
        cfg_en = 3'b010;
        cyc(3);
        rst_n = 1;
        cyc(1);
        cmp("R1 reset readback", rd_data, 8'h00);

        // R1/R8: write all ones; Start served first since master mode is 0
        wr(8'hFF);
        cmp("R1 write ignores bits 7:2", rd_data & 8'hFC, 8'h00);
        cmp("R8 both pending", rd_data, 8'h03);
        cyc(4);
        cmp("R8 restart still pending", rd_data, 8'h03);
        // R3/R2: engine makes the Start on the bus and reports done
        bus_start();
        pulse_start_done();
        cmp("R3 master mode set", {7'b0, rd_data[2]}, 8'h01);
        cmp("R6 start cleared", {7'b0, rd_data[0]}, 8'h00);
        wait_strobe(1, d);
        cmp("R7 restart issued in master mode", {7'b0, restart_req}, 8'h01);
        cyc(3);
        cmp("R10 start not reissued", {7'b0, start_req}, 8'h00);
        pulse_restart_done();
        cmp("R6 restart cleared", {7'b0, rd_data[1]}, 8'h00);
        bus_stop();
        pulse_stop_done();
        cmp("R3 master mode cleared", rd_data, 8'h00);

        // R2/R5: another master holds the bus; Start waits
        bus_start();
        cmp("R2 busy from foreign start", {7'b0, rd_data[3]}, 8'h01);
        wr(8'h01);
        cyc(10);
        cmp("R5 start held while busy", {7'b0, start_req}, 8'h00);
        cmp("R3 master mode not set by foreign start", {7'b0, rd_data[2]}, 8'h00);
        bus_stop();
        wait_strobe(0, d);
        cmp("R5 start issued after bus frees", {7'b0, start_req}, 8'h01);
        cyc(2);
        bus_start();
        pulse_start_done();
        pulse_stop_done();
        bus_stop();

        // R6/R4: stray done pulses and a zero write change nothing
        pulse_restart_done();
        pulse_start_done();
        wr(8'h00);
        cmp("R6 stray done ignored", rd_data, 8'h00);
        cmp("R4 zero write no effect", rd_data, 8'h00);

        // R7/R9: restart request without master mode is stranded; disable drops it
        wr(8'h02);
        cyc(6);
        cmp("R7 restart held outside master mode", {7'b0, rd_data[1]}, 8'h01);
        @(negedge clk); cfg_en = '0;
        cyc(2);
        cmp("R9 disable clears", rd_data, 8'h00);
        wr(8'h03);
        cmp("R9 write ignored while disabled", rd_data, 8'h00);
        @(negedge clk); cfg_en = 3'b100;
        cyc(2);

        // R6: done wins over a write of 1 on the same edge
        wr(8'h01);
        wait_strobe(0, d);
        cyc(2);
        @(negedge clk); sdone = 1; wr_en = 1; wr_data = 8'h01;
        @(negedge clk); sdone = 0; wr_en = 0; wr_data = 8'h00;
        cmp("R6 done beats write", {7'b0, rd_data[0]}, 8'h00);
        cmp("R3 master mode after own start", {7'b0, rd_data[2]}, 8'h01);

        // R8: both written while master: repeated Start first, Start stays pending
        bus_start();
        wr(8'h03);
        wait_strobe(1, d);
        cmp("R8 restart first in master mode", {7'b0, restart_req}, 8'h01);
        pulse_restart_done();
        cyc(4);
        cmp("R8 start still pending", rd_data & 8'h03, 8'h01);
        pulse_stop_done();
        bus_stop();
        wait_strobe(0, d);
        cmp("R5 start after stop", {7'b0, start_req}, 8'h01);
        cyc(2);
        pulse_start_done();
        cyc(4);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule